// File: doc/BRIEF.md
# Maskable interrupt latch and enable controller

This block collects interrupt requests from fourteen sources, numbered 2 through 15, into sticky pending latches. It decides on every clock whether one of them may be taken by the processor. Sources 2 and 3 cannot be masked. Sources 4 to 15 each have an individual enable bit, and a master enable bit gates all of them together. When a source may be taken, the block raises an accept strobe together with the 4-bit number of the winning source. The lowest-numbered eligible source wins.

Software reaches the latches and the enables through a byte-wide register port. A pending latch is cleared by writing a 0 to its bit, and writing a 1 to a latch bit changes nothing. Taking a source clears its latch and drops the master enable in the same clock edge. The interrupt handler must therefore re-arm the master enable itself before nested interrupts can occur.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset every latch, every enable bit and the master enable are 0. All four registers read 0x00 and `acc_valid` is low.
- R2: A high level on `req_i[k]` at a clock edge, for k from 2 to 15, sets latch k. Latches 7..2 read back in bits 7..2 of address 0x3C, and latches 15..8 read back in bits 7..0 of address 0x3D. `req_i[1:0]` have no effect.
- R3: A write to 0x3C or 0x3D clears each latch whose data bit is 0 and leaves unchanged each latch whose data bit is 1. Bits 1..0 written to 0x3C are ignored. Software keeps latches 2 and 3 by writing 1 to bits 2 and 3.
- R4: If a request and a software clear hit the same latch in the same cycle, the latch ends up set.
- R5: Address 0x3A holds the enables of sources 7..4 in bits 7..4 and the master enable in bit 0, and bits 3..1 read as 0. Address 0x3B holds the enables of sources 15..8 in bits 7..0. Any other address reads 0x00, and writes to it change nothing.
- R6: A pending source 2 or 3 is accepted whatever the master enable and the individual enables hold.
- R7: A pending source k from 4 to 15 is accepted only while the master enable is 1 and enable bit k is 1.
- R8: When several sources are eligible, `acc_idx` gives the lowest source number.
- R9: `acc_valid` is high in every cycle in which the registered state has an eligible source. At the following edge the accepted latch clears and the master enable drops to 0. If a write to 0x3A happens in that same cycle, the master enable instead takes the written bit 0.
- R10: A request for the source being accepted in that same cycle keeps its latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| rdata | output | 8 | Read data for `addr`, combinational |
| req_i | input | 16 | Request lines, bit k for source k (bits 1..0 unused) |
| acc_valid | output | 1 | A source is being accepted in this cycle |
| acc_idx | output | 4 | Number of the accepted source |

## Verification
Every write and every request pulse takes effect at the single rising edge where it is presented. Register reads are combinational, so the new contents can be read back in the first half of the following cycle. The accept outputs follow the registered state combinationally and rise in that same cycle. The latch clear and the master-enable drop that an acceptance causes show up one edge later. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples 2 ns after it. A result that arrives one edge late or one edge early therefore fails its check.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int SRC_N     = 16;
  localparam int IDX_W     = $clog2(SRC_N);
  localparam int FIRST_SRC = 2;
  localparam int FIRST_MSK = 4;

  localparam logic [SRC_N-1:0] LAT_IMPL = {SRC_N{1'b1}} << FIRST_SRC;
  localparam logic [SRC_N-1:0] EN_IMPL  = {SRC_N{1'b1}} << FIRST_MSK;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [SRC_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req,
  input  logic [SRC_N-1:0] sw_keep,
  input  logic [SRC_N-1:0] hw_clr,
  output logic [SRC_N-1:0] lat_q
);
  logic [SRC_N-1:0] lat_d;

  always_comb begin
    lat_d = ((lat_q & sw_keep & ~hw_clr) | req) & LAT_IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [7:0]       wdata,
  input  logic             accept,
  output logic [SRC_N-1:0] en_q,
  output logic             imf_q
);
  logic [SRC_N-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (we_lo) en_d[7:0]  = wdata;
    if (we_hi) en_d[15:8] = wdata;
    en_d = en_d & EN_IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      imf_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (we_lo)       imf_q <= wdata[0];
      else if (accept) imf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_ctl_pkg::*;
(
  input  logic [SRC_N-1:0] lat,
  input  logic [SRC_N-1:0] en,
  input  logic             imf,
  output logic             acc_valid,
  output logic [IDX_W-1:0] acc_idx,
  output logic [SRC_N-1:0] acc_onehot
);
  logic [SRC_N-1:0] elig;

  for (genvar g = 0; g < SRC_N; g++) begin : g_elig
    if (g < FIRST_SRC) begin : g_none
      assign elig[g] = 1'b0;
    end else if (g < FIRST_MSK) begin : g_nmi
      assign elig[g] = lat[g];
    end else begin : g_mask
      assign elig[g] = lat[g] & en[g] & imf;
    end
  end

  always_comb begin
    acc_valid  = |elig;
    acc_idx    = lowest_set(elig);
    acc_onehot = acc_valid ? (SRC_N'(1) << acc_idx) : '0;
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] A_EN_LO  = 8'h3A,
  parameter logic [7:0] A_EN_HI  = 8'h3B,
  parameter logic [7:0] A_LAT_LO = 8'h3C,
  parameter logic [7:0] A_LAT_HI = 8'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  output logic [7:0]        rdata,
  input  logic [SRC_N-1:0]  req_i,
  output logic              acc_valid,
  output logic [IDX_W-1:0]  acc_idx
);
  logic [SRC_N-1:0] lat_q, en_q, sw_keep, acc_onehot;
  logic             imf_q;
  logic             wr_lat_lo, wr_lat_hi, wr_en_lo, wr_en_hi;

  assign wr_lat_lo = wr_en && (addr == ADDR_W'(A_LAT_LO));
  assign wr_lat_hi = wr_en && (addr == ADDR_W'(A_LAT_HI));
  assign wr_en_lo  = wr_en && (addr == ADDR_W'(A_EN_LO));
  assign wr_en_hi  = wr_en && (addr == ADDR_W'(A_EN_HI));

  always_comb begin
    sw_keep = '1;
    if (wr_lat_lo) sw_keep[7:2]  = wdata[7:2];
    if (wr_lat_hi) sw_keep[15:8] = wdata;
  end

  irq_latch_bank u_lat (
    .clk(clk), .rst_n(rst_n), .req(req_i), .sw_keep(sw_keep),
    .hw_clr(acc_onehot), .lat_q(lat_q)
  );

  irq_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .we_lo(wr_en_lo), .we_hi(wr_en_hi),
    .wdata(wdata), .accept(acc_valid), .en_q(en_q), .imf_q(imf_q)
  );

  irq_prio_sel u_sel (
    .lat(lat_q), .en(en_q), .imf(imf_q),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_onehot(acc_onehot)
  );

  always_comb begin
    if (addr == ADDR_W'(A_LAT_LO))     rdata = {lat_q[7:2], 2'b00};
    else if (addr == ADDR_W'(A_LAT_HI)) rdata = lat_q[15:8];
    else if (addr == ADDR_W'(A_EN_LO))  rdata = {en_q[7:4], 3'b000, imf_q};
    else if (addr == ADDR_W'(A_EN_HI))  rdata = en_q[15:8];
    else                                rdata = 8'h00;
  end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irq_ctl_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] A_EN_LO = 8'h3A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [SRC_N-1:0]  req_i,
  input logic              acc_valid,
  input logic [IDX_W-1:0]  acc_idx,
  input logic [SRC_N-1:0]  lat_q,
  input logic [SRC_N-1:0]  en_q,
  input logic              imf_q
);
  AST_REQ_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(req_i) & LAT_IMPL & ~lat_q) == '0)); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i & LAT_IMPL) == '0) |=> ((lat_q & ~$past(lat_q)) == '0)); // R3

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_idx >= IDX_W'(FIRST_SRC))); // R6

  AST_MASKED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_idx >= IDX_W'(FIRST_MSK)) |-> (imf_q && en_q[acc_idx])); // R7

  AST_SRC2_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q[FIRST_SRC] |-> (acc_valid && acc_idx == IDX_W'(FIRST_SRC))); // R8

  AST_IMF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(wr_en && addr == ADDR_W'(A_EN_LO))) |=> !imf_q); // R9

  AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !req_i[acc_idx]) |=> !lat_q[$past(acc_idx)]); // R9

  AST_REREQ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && req_i[acc_idx]) |=> lat_q[$past(acc_idx)]); // R10
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.ADDR_W(ADDR_W), .A_EN_LO(A_EN_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .req_i(req_i),
  .acc_valid(acc_valid), .acc_idx(acc_idx), .lat_q(lat_q), .en_q(en_q),
  .imf_q(imf_q)
);

// File: tb/tb_irq_latch_ctrl.sv
`timescale 1ns/1ps
module tb_irq_latch_ctrl;
  localparam logic [7:0] EN_LO = 8'h3A, EN_HI = 8'h3B, LAT_LO = 8'h3C, LAT_HI = 8'h3D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        wr_en = 1'b0;
  logic [15:0] req_i = '0;
  logic        acc_valid;
  logic [3:0]  acc_idx;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_latch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .req_i(req_i), .acc_valid(acc_valid), .acc_idx(acc_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic [15:0] r);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; req_i = r;
    @(posedge clk);
    #2;
    wr_en = 1'b0; req_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(LAT_LO, lo);
    rd(LAT_HI, hi);
    v = {hi, lo};
  endtask

  task automatic clear_all();
    step(1'b1, EN_LO, 8'h00, '0);
    step(1'b1, EN_HI, 8'h00, '0);
    step(1'b1, LAT_HI, 8'h00, '0);
    step(1'b1, LAT_LO, 8'h0C, '0);
  endtask

  function automatic int low_bit(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] l, m, expl;
    int          e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(LAT_LO, v); chk(v == 0, "R1 lat_lo", v, 0);
    rd(LAT_HI, v); chk(v == 0, "R1 lat_hi", v, 0);
    rd(EN_LO, v);  chk(v == 0, "R1 en_lo", v, 0);
    rd(EN_HI, v);  chk(v == 0, "R1 en_hi", v, 0);
    chk(!acc_valid, "R1 acc_valid", acc_valid, 0);

    // R5 enable register layout, unmapped address
    step(1'b1, EN_HI, 8'h5A, '0);
    rd(EN_HI, v); chk(v == 8'h5A, "R5 en_hi", v, 8'h5A);
    step(1'b1, EN_LO, 8'hEE, '0);
    rd(EN_LO, v); chk(v == 8'hE0, "R5 en_lo", v, 8'hE0);
    step(1'b1, 8'h40, 8'hFF, '0);
    rd(8'h40, v); chk(v == 0, "R5 unmapped", v, 0);
    rd(EN_HI, v); chk(v == 8'h5A, "R5 unmapped write", v, 8'h5A);
    clear_all();

    // R2 unused request lines
    step(1'b0, 8'h00, 8'h00, 16'h0003);
    rd16(l); chk(l == 0, "R2 req bits 1:0", l, 0);
    chk(!acc_valid, "R2 no accept", acc_valid, 0);

    // R2/R3/R7 sweep maskable sources with master enable off
    for (int k = 4; k < 16; k++) begin
      step(1'b0, 8'h00, 8'h00, 16'h1 << k);
      rd16(l); chk(l == (16'h1 << k), "R2 latch set", l, 16'h1 << k);
      chk(!acc_valid, "R7 blocked by master", acc_valid, 0);
      m = ~(16'h1 << k);
      if (k < 8) step(1'b1, LAT_LO, m[7:0], '0);
      else       step(1'b1, LAT_HI, m[15:8], '0);
      rd16(l); chk(l == 0, "R3 write zero clears", l, 0);
    end

    // R3 write ones has no effect; R4 request beats clear
    step(1'b0, 8'h00, 8'h00, 16'h1200);
    step(1'b1, LAT_HI, 8'hFF, '0);
    rd(LAT_HI, v); chk(v == 8'h12, "R3 write ones", v, 8'h12);
    step(1'b1, LAT_HI, 8'h00, 16'h0200);
    rd(LAT_HI, v); chk(v == 8'h02, "R4 set wins", v, 8'h02);
    step(1'b1, LAT_HI, 8'hFD, '0);
    rd(LAT_HI, v); chk(v == 8'h00, "R3 clear bit 9", v, 0);

    // R7/R8/R9 sweep of enable masks
    for (int t = 0; t < 16; t++) begin
      if (t < 12)       m = 16'h0010 << t;
      else if (t == 12) m = 16'h0000;
      else if (t == 13) m = 16'hFFF0;
      else if (t == 14) m = 16'hA000;
      else              m = 16'h0F30;
      clear_all();
      step(1'b0, 8'h00, 8'h00, 16'hFFF0);
      step(1'b1, EN_HI, m[15:8], '0);
      step(1'b1, EN_LO, {m[7:4], 4'b0001}, '0);
      e = low_bit(m);
      chk(acc_valid == (e >= 0), "R7 accept valid", acc_valid, e >= 0);
      if (e >= 0) chk(acc_idx == e[3:0], "R8 lowest enabled", acc_idx, e);
      step(1'b0, 8'h00, 8'h00, '0);
      rd(EN_LO, v);
      if (e >= 0) begin
        chk(v == {m[7:4], 4'b0000}, "R9 master dropped", v, {m[7:4], 4'b0000});
        expl = 16'hFFF0 & ~(16'h1 << e);
      end else begin
        chk(v == 8'h01, "R7 master kept", v, 8'h01);
        expl = 16'hFFF0;
      end
      rd16(l); chk(l == expl, "R9 latch cleared", l, expl);
      chk(!acc_valid, "R9 single pulse", acc_valid, 0);
    end

    // R6/R8 non-maskable sources ahead of source 4
    clear_all();
    step(1'b1, EN_LO, 8'h11, '0);
    step(1'b0, 8'h00, 8'h00, 16'h001C);
    chk(acc_valid && acc_idx == 2, "R8 source 2 first", acc_idx, 2);
    step(1'b0, 8'h00, 8'h00, '0);
    chk(acc_valid && acc_idx == 3, "R6 source 3 with master off", acc_idx, 3);
    rd(EN_LO, v); chk(v == 8'h10, "R9 master off", v, 8'h10);
    step(1'b0, 8'h00, 8'h00, '0);
    chk(!acc_valid, "R7 source 4 held", acc_valid, 0);
    rd(LAT_LO, v); chk(v == 8'h10, "R9 nmi latches cleared", v, 8'h10);

    // R10 re-request during acceptance
    clear_all();
    step(1'b0, 8'h00, 8'h00, 16'h0004);
    chk(acc_valid && acc_idx == 2, "R6 source 2 accepted", acc_idx, 2);
    step(1'b0, 8'h00, 8'h00, 16'h0004);
    rd(LAT_LO, v); chk(v == 8'h04, "R10 latch kept", v, 8'h04);
    chk(acc_valid && acc_idx == 2, "R10 accepted again", acc_idx, 2);
    step(1'b0, 8'h00, 8'h00, '0);
    rd(LAT_LO, v); chk(v == 8'h00, "R10 then cleared", v, 0);

    // R9 master enable write coinciding with an acceptance
    step(1'b0, 8'h00, 8'h00, 16'h0008);
    chk(acc_valid && acc_idx == 3, "R6 source 3 accepted", acc_idx, 3);
    step(1'b1, EN_LO, 8'h01, '0);
    rd(EN_LO, v); chk(v == 8'h01, "R9 write beats drop", v, 8'h01);
    rd(LAT_LO, v); chk(v == 8'h00, "R9 latch 3 cleared", v, 0);
    step(1'b1, EN_LO, 8'h00, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule